// File: doc/BRIEF.md
# Multi-Mode Radix-2 Butterfly Unit

This block performs one radix-2 butterfly on complex signed fixed-point samples. A caller presents two complex operands A and B, one complex twiddle W, a 2-bit mode and an inverse flag, then pulses `start`. The unit captures everything on that edge and runs a fixed 16-cycle sequence. A single real multiplier forms the four partial products of the complex twiddle product in turn. The sequence then applies an optional quarter-turn rotation, rounds and saturates the product, and forms the halved sum and difference. A one-cycle `done` pulse marks the cycle in which both results first show on the outputs.

The twiddle product can go in one of two places. In the time-decimation modes it scales B before the sum and difference. In the frequency-decimation modes it scales the difference after the sum and difference. Each placement also has a variant that turns the product by a further quarter turn. A twiddle table that covers only part of the circle can then reach every index. The inverse flag lets the forward and inverse transforms share one table: it conjugates the twiddle and reverses the direction of the extra rotation.

Top module: `bfly2_unit`

## Requirements
- R1: A synchronous active-low reset clears `busy`, `done` and all four result outputs to zero on the next rising edge, and this also aborts an operation in progress.
- R2: An accepted start sets `busy` for exactly 16 cycles. `done` is high for exactly one cycle, on the cycle in which `busy` falls, 16 rising edges after the edge that sampled `start`. Timing is the same in every mode.
- R3: A `start` seen while `busy` is high is ignored. It does not change the timing and does not change the operands used by the operation in flight.
- R4: Mode 2'b00 (time decimation): T = round(B·W / 2^15), saturated per component to 16 bits; X = (A+T)/2 and Y = (A−T)/2.
- R5: Mode 2'b10 (frequency decimation): X = (A+B)/2 and Y = round((A−B)·W / 2^16), saturated per component.
- R6: Modes 2'b01 and 2'b11 follow R4 and R5 respectively, but the exact twiddle product is multiplied by −j, mapping (re, im) to (im, −re), before rounding.
- R7: When `inverse` is high, the twiddle imaginary part is negated before the multiply, and the extra rotation becomes +j, mapping (re, im) to (−im, re).
- R8: Every halving and every product scaling rounds half up: add half of one output LSB, then floor.
- R9: The twiddle product and every result saturate to the 16-bit two's-complement range [−32768, 32767] instead of wrapping.
- R10: X and Y change only on the cycle in which `done` is high, and hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start pulse; captures operands when idle |
| mode | input | 2 | bit1: frequency decimation, bit0: extra quarter-turn |
| inverse | input | 1 | Conjugate twiddle and reverse the extra rotation |
| a_re | input | 16 | Operand A real, signed |
| a_im | input | 16 | Operand A imaginary, signed |
| b_re | input | 16 | Operand B real, signed |
| b_im | input | 16 | Operand B imaginary, signed |
| w_re | input | 16 | Twiddle real, signed Q1.15 |
| w_im | input | 16 | Twiddle imaginary, signed Q1.15 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| x_re | output | 16 | Result X real |
| x_im | output | 16 | Result X imaginary |
| y_re | output | 16 | Result Y real |
| y_im | output | 16 | Result Y imaginary |

## Verification
The embedded properties assume that `rst_n` is held low for at least one rising edge before the first operation. This ensures the latched operands, the accumulator and the outputs start from known values. They assume nothing about when `start` arrives, so the stimulus deliberately pulses it in the middle of an operation and on the cycle right after `done`. They also assume that mode, inverse and operand pins matter only on the accepted start edge, so the stimulus changes them freely while the unit is busy. A reset is also applied halfway through a run to confirm the sequencer returns to idle.

// File: rtl/bfly_pkg.sv
// Package bfly_pkg
// Shared mode encoding and the step schedule of the butterfly sequencer.
// Assumes the sequence length is at least MIN_LATENCY cycles.
package bfly_pkg;

    typedef enum logic [1:0] {
        MODE_TIME      = 2'b00,
        MODE_TIME_ROT  = 2'b01,
        MODE_FREQ      = 2'b10,
        MODE_FREQ_ROT  = 2'b11
    } bfly_mode_e;

    // Step numbers within one operation (counter values while busy)
    localparam int STEP_PREP   = 0;  // form multiplicand and effective twiddle
    localparam int STEP_RR     = 1;  // accumulate re*re
    localparam int STEP_II     = 2;  // subtract im*im
    localparam int STEP_RI     = 3;  // accumulate re*im
    localparam int STEP_IR     = 4;  // accumulate im*re
    localparam int STEP_ROUND  = 5;  // rotate, round, saturate product
    localparam int MIN_LATENCY = 7;

endpackage

// File: rtl/bfly_ctrl.sv
// Module bfly_ctrl
// Fixed-length sequencer: accepts a start when idle, counts LATENCY cycles,
// then raises done for one cycle. Starts arriving while busy are dropped.
// Assumes LATENCY >= bfly_pkg::MIN_LATENCY.
module bfly_ctrl #(
    parameter int LATENCY = 16,
    parameter int CW      = $clog2(LATENCY)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          accept,
    output logic          finish,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

    // Accept only when idle
    assign accept = start && !busy;
    // Final counted cycle of an operation
    assign finish = busy && (cnt == LAST);

    // Step counter, busy and done flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end
    end

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/bfly_cmac.sv
// Module bfly_cmac
// Sequenced complex multiply with one real multiplier. It forms the
// multiplicand (B, or A-B in frequency-decimation modes), conjugates the
// twiddle for inverse transforms, accumulates four partial products, then
// applies the optional quarter-turn, rounds half up and saturates.
// Assumes operands stay stable while busy (they are latched by the top).
module bfly_cmac #(
    parameter int DW = 16,
    parameter int WW = 16,
    parameter int CW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy,
    input  logic [CW-1:0]        cnt,
    input  logic                 is_freq,
    input  logic                 rot,
    input  logic                 inv,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [WW-1:0] w_re,
    input  logic signed [WW-1:0] w_im,
    output logic signed [DW-1:0] t_re,
    output logic signed [DW-1:0] t_im
);
    import bfly_pkg::*;

    localparam int MW = DW + 1;
    localparam int EW = WW + 1;
    localparam int PW = MW + EW;
    localparam int AW = PW + 2;
    localparam int FB = WW - 1;

    localparam logic [CW-1:0] S_PREP  = CW'(STEP_PREP);
    localparam logic [CW-1:0] S_RR    = CW'(STEP_RR);
    localparam logic [CW-1:0] S_II    = CW'(STEP_II);
    localparam logic [CW-1:0] S_RI    = CW'(STEP_RI);
    localparam logic [CW-1:0] S_IR    = CW'(STEP_IR);
    localparam logic [CW-1:0] S_ROUND = CW'(STEP_ROUND);

    localparam logic signed [AW-1:0] HALF_T = AW'(1) <<< (FB - 1);
    localparam logic signed [AW-1:0] HALF_F = AW'(1) <<< FB;
    localparam logic signed [AW-1:0] SMAX   = (AW'(1) <<< (DW - 1)) - AW'(1);
    localparam logic signed [AW-1:0] SMIN   = -SMAX - AW'(1);

    logic signed [MW-1:0] m_re, m_im;
    logic signed [EW-1:0] we_re, we_im;
    logic signed [AW-1:0] acc_re, acc_im;
    logic signed [MW-1:0] op_m;
    logic signed [EW-1:0] op_w;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_x;
    logic signed [AW-1:0] rot_re, rot_im, rnd_re, rnd_im;

    // Clamp a wide value into the DW-bit signed range
    function automatic logic signed [DW-1:0] clamp(input logic signed [AW-1:0] v);
        if (v > SMAX)      return {1'b0, {(DW-1){1'b1}}};
        else if (v < SMIN) return {1'b1, {(DW-1){1'b0}}};
        else               return v[DW-1:0];
    endfunction

    // Route the partial-product operands to the single multiplier
    always_comb begin
        op_m = m_re;
        op_w = we_re;
        case (cnt)
            S_II:    begin op_m = m_im; op_w = we_im; end
            S_RI:    begin op_m = m_re; op_w = we_im; end
            S_IR:    begin op_m = m_im; op_w = we_re; end
            default: begin op_m = m_re; op_w = we_re; end
        endcase
    end

    // Shared real multiplier, sign-extended into the accumulator width
    assign prod   = op_m * op_w;
    assign prod_x = {{(AW-PW){prod[PW-1]}}, prod};

    // Optional quarter-turn: -j forward, +j inverse
    always_comb begin
        rot_re = acc_re;
        rot_im = acc_im;
        if (rot) begin
            if (inv) begin
                rot_re = -acc_im;
                rot_im = acc_re;
            end else begin
                rot_re = acc_im;
                rot_im = -acc_re;
            end
        end
    end

    // Round half up; frequency modes fold the final halving into the shift
    always_comb begin
        if (is_freq) begin
            rnd_re = (rot_re + HALF_F) >>> (FB + 1);
            rnd_im = (rot_im + HALF_F) >>> (FB + 1);
        end else begin
            rnd_re = (rot_re + HALF_T) >>> FB;
            rnd_im = (rot_im + HALF_T) >>> FB;
        end
    end

    // Step-by-step operand prep, accumulation and product capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_re   <= '0;
            m_im   <= '0;
            we_re  <= '0;
            we_im  <= '0;
            acc_re <= '0;
            acc_im <= '0;
            t_re   <= '0;
            t_im   <= '0;
        end else if (busy) begin
            case (cnt)
                S_PREP: begin
                    if (is_freq) begin
                        m_re <= {a_re[DW-1], a_re} - {b_re[DW-1], b_re};
                        m_im <= {a_im[DW-1], a_im} - {b_im[DW-1], b_im};
                    end else begin
                        m_re <= {b_re[DW-1], b_re};
                        m_im <= {b_im[DW-1], b_im};
                    end
                    we_re  <= {w_re[WW-1], w_re};
                    we_im  <= inv ? -{w_im[WW-1], w_im} : {w_im[WW-1], w_im};
                    acc_re <= '0;
                    acc_im <= '0;
                end
                S_RR:    acc_re <= acc_re + prod_x;
                S_II:    acc_re <= acc_re - prod_x;
                S_RI:    acc_im <= acc_im + prod_x;
                S_IR:    acc_im <= acc_im + prod_x;
                S_ROUND: begin
                    t_re <= clamp(rnd_re);
                    t_im <= clamp(rnd_im);
                end
                default: ;
            endcase
        end
    end

    // The scaled product may change only at its capture step (R4/R5 ordering)
    assert_product_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && cnt == S_ROUND) |=> ($stable(t_re) && $stable(t_im)));

    // Multiplicand is fixed once prepared, through the multiply steps
    assert_operand_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != S_PREP) |=> ($stable(m_re) && $stable(m_im)));

endmodule

// File: rtl/bfly_combine.sv
// Module bfly_combine
// Forms the halved sum and difference with round-half-up and saturation,
// and loads X and Y only on the final step of an operation.
// Assumes t_re/t_im are settled before finish rises.
module bfly_combine #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 finish,
    input  logic                 is_freq,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [DW-1:0] t_re,
    input  logic signed [DW-1:0] t_im,
    output logic signed [DW-1:0] x_re,
    output logic signed [DW-1:0] x_im,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);

    localparam int HW = DW + 2;
    localparam logic signed [HW-1:0] SMAX = (HW'(1) <<< (DW - 1)) - HW'(1);
    localparam logic signed [HW-1:0] SMIN = -SMAX - HW'(1);

    logic signed [DW-1:0] s_re, s_im;
    logic signed [DW-1:0] nx_re, nx_im, ny_re, ny_im;

    // Halve p+q (or p-q) with round half up and clamp to DW bits
    function automatic logic signed [DW-1:0] halve(input logic signed [DW-1:0] p,
                                                   input logic signed [DW-1:0] q,
                                                   input logic sub);
        logic signed [HW-1:0] pe, qe, v;
        pe = {{2{p[DW-1]}}, p};
        qe = {{2{q[DW-1]}}, q};
        v  = ((sub ? (pe - qe) : (pe + qe)) + HW'(1)) >>> 1;
        if (v > SMAX)      return {1'b0, {(DW-1){1'b1}}};
        else if (v < SMIN) return {1'b1, {(DW-1){1'b0}}};
        else               return v[DW-1:0];
    endfunction

    // Second operand of the sum: B in frequency modes, scaled product otherwise
    assign s_re = is_freq ? b_re : t_re;
    assign s_im = is_freq ? b_im : t_im;

    // Next-result selection per placement of the twiddle multiply
    always_comb begin
        nx_re = halve(a_re, s_re, 1'b0);
        nx_im = halve(a_im, s_im, 1'b0);
        if (is_freq) begin
            ny_re = t_re;
            ny_im = t_im;
        end else begin
            ny_re = halve(a_re, t_re, 1'b1);
            ny_im = halve(a_im, t_im, 1'b1);
        end
    end

    // Result registers, loaded only on the last step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_re <= '0;
            x_im <= '0;
            y_re <= '0;
            y_im <= '0;
        end else if (finish) begin
            x_re <= nx_re;
            x_im <= nx_im;
            y_re <= ny_re;
            y_im <= ny_im;
        end
    end

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> ($stable(x_re) && $stable(x_im) && $stable(y_re) && $stable(y_im)));

endmodule

// File: rtl/bfly2_unit.sv
// Module bfly2_unit
// Top of the multi-mode radix-2 butterfly. Captures operands, mode and the
// inverse flag on an accepted start, then runs the sequencer, the shared
// complex multiplier and the sum/difference stage.
// Assumes a reset before first use; pins are only sampled on accepted starts.
module bfly2_unit #(
    parameter int DW      = 16,
    parameter int WW      = 16,
    parameter int LATENCY = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           mode,
    input  logic                 inverse,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [WW-1:0] w_re,
    input  logic signed [WW-1:0] w_im,
    output logic                 busy,
    output logic                 done,
    output logic signed [DW-1:0] x_re,
    output logic signed [DW-1:0] x_im,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);
    import bfly_pkg::*;

    localparam int CW = $clog2(LATENCY);

    logic                 accept, finish;
    logic [CW-1:0]        cnt;
    bfly_mode_e           mode_q;
    logic                 inv_q;
    logic signed [DW-1:0] ar_q, ai_q, br_q, bi_q;
    logic signed [WW-1:0] wr_q, wi_q;
    logic signed [DW-1:0] t_re, t_im;
    logic                 is_freq, rot;

    assign is_freq = mode_q[1];
    assign rot     = mode_q[0];

    // Capture the operation's inputs on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_TIME;
            inv_q  <= 1'b0;
            ar_q   <= '0;
            ai_q   <= '0;
            br_q   <= '0;
            bi_q   <= '0;
            wr_q   <= '0;
            wi_q   <= '0;
        end else if (accept) begin
            mode_q <= bfly_mode_e'(mode);
            inv_q  <= inverse;
            ar_q   <= a_re;
            ai_q   <= a_im;
            br_q   <= b_re;
            bi_q   <= b_im;
            wr_q   <= w_re;
            wi_q   <= w_im;
        end
    end

    bfly_ctrl #(.LATENCY(LATENCY), .CW(CW)) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .finish (finish),
        .busy   (busy),
        .done   (done),
        .cnt    (cnt)
    );

    bfly_cmac #(.DW(DW), .WW(WW), .CW(CW)) cmac_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .cnt     (cnt),
        .is_freq (is_freq),
        .rot     (rot),
        .inv     (inv_q),
        .a_re    (ar_q),
        .a_im    (ai_q),
        .b_re    (br_q),
        .b_im    (bi_q),
        .w_re    (wr_q),
        .w_im    (wi_q),
        .t_re    (t_re),
        .t_im    (t_im)
    );

    bfly_combine #(.DW(DW)) comb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .finish  (finish),
        .is_freq (is_freq),
        .a_re    (ar_q),
        .a_im    (ai_q),
        .b_re    (br_q),
        .b_im    (bi_q),
        .t_re    (t_re),
        .t_im    (t_im),
        .x_re    (x_re),
        .x_im    (x_im),
        .y_re    (y_re),
        .y_im    (y_im)
    );

    assert_latch_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(mode_q) && $stable(inv_q) && $stable(br_q) && $stable(wr_q)));

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && !done));

endmodule

// File: tb/bfly2_unit_tb_top.sv
// Bench for bfly2_unit: a behavioural reference model built on integers,
// updated every rising edge and compared with the ports every falling edge.
module bfly2_unit_tb_top;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [1:0]         mode = 2'b00;
    logic               inverse = 1'b0;
    logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic signed [15:0] w_re = '0, w_im = '0;
    logic               busy, done;
    logic signed [15:0] x_re, x_im, y_re, y_im;

    int    n_total = 0;
    int    n_bad   = 0;
    bit    ended   = 0;
    string drv_tag = "R4";

    always #5 clk = ~clk;

    bfly2_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .inverse(inverse),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .w_re(w_re), .w_im(w_im), .busy(busy), .done(done),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im)
    );

    // ---------------- reference arithmetic ----------------
    function automatic longint clip16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint half_up(input longint v, input int sh);
        return (v + (longint'(1) <<< (sh - 1))) >>> sh;
    endfunction

    // ---------------- reference model ----------------
    int     rem = 0;
    bit     m_done = 0;
    bit     seen_reset = 0;
    longint e_xr = 0, e_xi = 0, e_yr = 0, e_yi = 0;
    longint p_xr, p_xi, p_yr, p_yi;
    string  e_tag = "R1";
    string  p_tag = "R4";

    task automatic model_launch();
        longint mr, mi, wr, wi, pr, pi, tmp, tr, ti;
        bit freq, turn;
        freq = mode[1];
        turn = mode[0];
        mr = freq ? longint'(a_re) - longint'(b_re) : longint'(b_re);
        mi = freq ? longint'(a_im) - longint'(b_im) : longint'(b_im);
        wr = longint'(w_re);
        wi = inverse ? -longint'(w_im) : longint'(w_im);
        pr = mr * wr - mi * wi;
        pi = mr * wi + mi * wr;
        if (turn) begin
            tmp = pr;
            if (inverse) begin pr = -pi; pi = tmp;  end
            else         begin pr = pi;  pi = -tmp; end
        end
        tr = clip16(half_up(pr, freq ? 16 : 15));
        ti = clip16(half_up(pi, freq ? 16 : 15));
        if (freq) begin
            p_xr = clip16(half_up(longint'(a_re) + longint'(b_re), 1));
            p_xi = clip16(half_up(longint'(a_im) + longint'(b_im), 1));
            p_yr = tr;
            p_yi = ti;
        end else begin
            p_xr = clip16(half_up(longint'(a_re) + tr, 1));
            p_xi = clip16(half_up(longint'(a_im) + ti, 1));
            p_yr = clip16(half_up(longint'(a_re) - tr, 1));
            p_yi = clip16(half_up(longint'(a_im) - ti, 1));
        end
        p_tag = drv_tag;
    endtask

    // Advance the model on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            rem = 0; m_done = 0; seen_reset = 1;
            e_xr = 0; e_xi = 0; e_yr = 0; e_yi = 0; e_tag = "R1";
        end else if (rem > 0) begin
            rem = rem - 1;
            if (rem == 0) begin
                m_done = 1;
                e_xr = p_xr; e_xi = p_xi; e_yr = p_yr; e_yi = p_yi; e_tag = p_tag;
            end else begin
                m_done = 0;
            end
        end else begin
            m_done = 0;
            if (start) begin
                rem = 16;
                model_launch();
            end
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_total++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare ports with the model on every falling edge
    always @(negedge clk) begin
        if (seen_reset && !ended) begin
            string ot;
            ot = !rst_n ? "R1" : (m_done ? e_tag : "R10");
            check(rst_n ? "R2" : "R1", "busy", longint'(busy), longint'(rem > 0));
            check(rst_n ? "R2" : "R1", "done", longint'(done), longint'(m_done));
            check(ot, "x_re", longint'(x_re), e_xr);
            check(ot, "x_im", longint'(x_im), e_xi);
            check(ot, "y_re", longint'(y_re), e_yr);
            check(ot, "y_im", longint'(y_im), e_yi);
        end
    end

    // ---------------- stimulus ----------------
    function automatic string tag_for(input logic [1:0] md, input logic iv);
        if (iv)     return "R7";
        if (md[0])  return "R6";
        if (md[1])  return "R5";
        return "R4";
    endfunction

    task automatic drive(input logic [1:0] md, input logic iv,
                         input int ar, input int ai, input int br, input int bi,
                         input int wr, input int wi, input string tg);
        @(negedge clk);
        mode = md; inverse = iv;
        a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
        w_re = 16'(wr); w_im = 16'(wi);
        drv_tag = tg;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] md, input logic iv,
                          input int ar, input int ai, input int br, input int bi,
                          input int wr, input int wi, input string tg);
        drive(md, iv, ar, ai, br, bi, wr, wi, tg);
        repeat (16) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R8: round-half-up on halving, W = 0 so T = 0
        run_op(2'b00, 1'b0, 3, -3, 0, 0, 0, 0, "R8");
        check("R8", "x_re const", longint'(x_re), 2);
        check("R8", "x_im const", longint'(x_im), -1);

        // R4: W close to +1, W = -j
        run_op(2'b00, 1'b0, 100, 200, 1000, -2000, 32767, 0, "R4");
        run_op(2'b00, 1'b0, -500, 700, 1234, 4321, 0, -32768, "R4");
        // R5: frequency decimation
        run_op(2'b10, 1'b0, 20000, -15000, -12000, 9000, 23170, -23170, "R5");
        // R6: extra quarter turn in both placements
        run_op(2'b01, 1'b0, 300, -400, 5000, 6000, 30000, 12000, "R6");
        run_op(2'b11, 1'b0, -7000, 8000, 9000, -1000, 12540, -30274, "R6");
        // R7: inverse in every mode
        for (int m = 0; m < 4; m++)
            run_op(2'(m), 1'b1, 1111, -2222, 3333, -4444, 27000, 18000, "R7");

        // R9: saturated twiddle product, checked against constants
        run_op(2'b00, 1'b0, 0, 0, -32768, -32768, -32768, 0, "R9");
        check("R9", "x_re const", longint'(x_re), 16384);
        check("R9", "y_re const", longint'(y_re), -16383);
        run_op(2'b10, 1'b0, 32767, -32768, -32768, 32767, -32768, -32768, "R9");
        run_op(2'b00, 1'b0, 32767, -32768, 32767, -32768, 32767, 32767, "R9");

        // R3: start pulse in the middle of an operation
        drive(2'b00, 1'b0, 10, 20, 30, 40, 16384, 0, "R3");
        repeat (4) @(negedge clk);
        mode = 2'b11; inverse = 1'b1; b_re = 16'sd9999; w_re = -16'sd100;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (14) @(negedge clk);

        // R2: start on the cycle right after done, back to back
        drive(2'b10, 1'b0, 400, 500, 600, 700, 1000, 2000, "R2");
        repeat (15) @(negedge clk);
        drive(2'b01, 1'b0, 800, 900, 100, 200, 3000, 4000, "R2");
        repeat (16) @(negedge clk);

        // R1: reset in the middle of an operation
        drive(2'b11, 1'b0, 1, 2, 3, 4, 5, 6, "R1");
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (18) @(negedge clk);

        // Mixed pseudo-random operations across all modes
        for (int k = 0; k < 160; k++) begin
            logic [1:0] md;
            logic       iv;
            md = 2'($urandom_range(0, 3));
            iv = 1'($urandom_range(0, 1));
            run_op(md, iv,
                   int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
                   int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
                   int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
                   tag_for(md, iv));
        end

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule